// File: doc/BRIEF.md
# Dissemination Barrier Flag Engine

This block synchronises a fixed group of participants without any central counter. Each participant raises a start strobe when it reaches the barrier. The block then runs a sequence of pairwise handshakes on a small array of arrival flags. Each participant gets a one-cycle done pulse once it is known that every member of the group has arrived. After that pulse the participant is idle again, and the next barrier can follow at once.

For participant i, the work is split into ceil(log2 P) rounds. In round s, the participant notifies participant (i + 2^s) mod P by setting the flag that belongs to that participant and round. It then waits for its own flag for round s, which an incoming partner sets, and clears it. The flag storage is P × ceil(log2 P) registers, and no flag is ever written from two places in the same round.

Top module: `dsb_engine`

## Requirements
- R1: The barrier runs S = ceil(log2 P) rounds. Each round takes four cycles: wait for the partner flag to be empty, set it, wait for the own flag, then clear it. When all participants start on the same clock edge E, every done output is high in the cycle that follows edge E + 4·S.
- R2: In round s, participant i sets only flag (j, s), where j = (i + 2^s) mod P. There is one flag for each pair of participant and round.
- R3: A participant sets its partner's round-s flag only after it has seen that flag at 0, so a flag is never set while it is already 1.
- R4: A participant clears its own round-s flag in the cycle after it sees the flag at 1, and only then. If a set and a clear reach the same flag in one cycle, the flag ends up at 1.
- R5: The barrier completes for P = 2, where the incoming and outgoing partners are the same participant, and for values of P that are not powers of two (range 2 to 16).
- R6: Done is a pulse one cycle long. The participant is idle in the next cycle and accepts a new start there.
- R7: No participant asserts done before every participant has asserted start for the current barrier.
- R8: A start strobe is ignored while the participant is busy with a barrier.
- R9: During and directly after synchronous active-low reset, all done outputs are 0, all flags are 0 and every participant is idle.
- R10: Each participant pulses done exactly once per barrier, and never without a barrier in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | P | One strobe per participant: it has reached the barrier |
| done | output | P | One-cycle pulse per participant: all participants have arrived |

## Verification
The group of eight is tested with four arrival patterns. When all participants arrive together, the exact four-cycle-per-round latency is pinned down, and a wrong partner or an extra round shows up as a shifted done. When arrivals are staggered in scrambled order, participants at different rounds must wait on each other correctly. When a single participant arrives forty cycles late, any path that lets the group finish early is caught. When start is strobed again during a barrier, a busy participant is shown to ignore it. Back-to-back barriers with no idle gap show whether the flags are empty and reusable. Groups of five and two run beside the main group, one to cover a size that is not a power of two and the other to cover a size where the incoming and outgoing partners coincide.

// File: rtl/dsb_pkg.sv
// Package: shared types for the dissemination barrier engine.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package dsb_pkg;

    // Per-participant sequencing state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CLEAR,
        ST_SET,
        ST_WAIT_OWN,
        ST_CLEAR,
        ST_DONE
    } dsb_state_e;

endpackage

// File: rtl/dsb_flag_array.sv
// Module: register array holding one arrival flag per (participant, round).
// Each bit is set or cleared by a one-hot request vector. When both arrive
// for the same bit in one cycle, the set wins.
// Assumes: the requesters never set a bit that is already 1 and never clear
// a bit that is 0; the assertions below guard both.
module dsb_flag_array #(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] flag_q
);

    genvar b;
    generate
        for (b = 0; b < NFLAG; b++) begin : g_bit
            // Hold one flag; set dominates clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[b] <= 1'b0;
                end else if (set_i[b]) begin
                    flag_q[b] <= 1'b1;
                end else if (clr_i[b]) begin
                    flag_q[b] <= 1'b0;
                end
            end
        end
    endgenerate

    AST_SET_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i & flag_q) == '0);  // R3
    AST_CLEAR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i & ~flag_q) == '0);  // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((flag_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));  // R4

endmodule

// File: rtl/dsb_agent.sv
// Module: sequencer for one participant. It walks the rounds, asks for the
// set of its outgoing partner's flag and the clear of its own flag, and
// pulses done after the last round.
// Assumes: the flag values on partner_flag_i / own_flag_i refer to the round
// in stage_o and the partner in tgt_o during the same cycle.
module dsb_agent
    import dsb_pkg::*;
#(
    parameter int P      = 8,
    parameter int ID     = 0,
    parameter int STAGES = 3,
    parameter int IDX_W  = 3,
    parameter int STG_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partner_flag_i,
    input  logic             own_flag_i,
    output logic             set_req_o,
    output logic             clr_req_o,
    output logic [IDX_W-1:0] tgt_o,
    output logic [STG_W-1:0] stage_o,
    output logic             done_o
);

    localparam logic [STG_W-1:0] LAST_STG = STG_W'(STAGES - 1);

    dsb_state_e       state_q, state_d;
    logic [STG_W-1:0] stage_q, stage_d;
    int unsigned      tgt_sum;

    // Outgoing partner for the current round: (ID + 2^stage) mod P.
    always_comb begin
        tgt_sum = ID + (32'd1 << stage_q);
        if (tgt_sum >= P) begin
            tgt_sum = tgt_sum - P;
        end
        tgt_o = IDX_W'(tgt_sum);
    end

    // Next-state and round-counter decision.
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) begin
                               state_d = ST_WAIT_CLEAR;
                               stage_d = '0;
                           end
            ST_WAIT_CLEAR: if (!partner_flag_i) state_d = ST_SET;
            ST_SET:        state_d = ST_WAIT_OWN;
            ST_WAIT_OWN:   if (own_flag_i) state_d = ST_CLEAR;
            ST_CLEAR:      if (stage_q == LAST_STG) begin
                               state_d = ST_DONE;
                           end else begin
                               state_d = ST_WAIT_CLEAR;
                               stage_d = stage_q + 1'b1;
                           end
            ST_DONE:       begin
                               state_d = ST_IDLE;
                               stage_d = '0;
                           end
            default:       state_d = ST_IDLE;
        endcase
    end

    // State and round registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    // Request and completion outputs decoded from the state.
    always_comb begin
        set_req_o = (state_q == ST_SET);
        clr_req_o = (state_q == ST_CLEAR);
        done_o    = (state_q == ST_DONE);
        stage_o   = stage_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R6
    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q <= LAST_STG);  // R1
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_OWN && start_i && !own_flag_i) |=> (state_q == ST_WAIT_OWN && $stable(stage_q)));  // R8
    AST_OWN_SEEN_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_o |-> $past(own_flag_i));  // R4

endmodule

// File: rtl/dsb_engine.sv
// Module: top of the dissemination barrier. It builds one agent per
// participant and the shared flag array, and routes each agent's set request
// to the flag of its partner and its clear request to its own flag.
// Assumes: 2 <= P <= 16; start is a level or strobe per participant that
// is only sampled while that participant is idle.
module dsb_engine #(
    parameter int P = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [P-1:0] start,
    output logic [P-1:0] done
);

    localparam int S     = $clog2(P);
    localparam int IDX_W = $clog2(P);
    localparam int STG_W = (S > 1) ? $clog2(S) : 1;
    localparam int NFLAG = P * S;

    logic [P-1:0]     set_req, clr_req, pflag, oflag;
    logic [IDX_W-1:0] tgt   [P];
    logic [STG_W-1:0] stg   [P];
    logic [NFLAG-1:0] set_vec, clr_vec, flags;

    genvar gi;
    generate
        for (gi = 0; gi < P; gi++) begin : g_agent
            dsb_agent #(
                .P(P), .ID(gi), .STAGES(S), .IDX_W(IDX_W), .STG_W(STG_W)
            ) u_agent (
                .clk            (clk),
                .rst_n          (rst_n),
                .start_i        (start[gi]),
                .partner_flag_i (pflag[gi]),
                .own_flag_i     (oflag[gi]),
                .set_req_o      (set_req[gi]),
                .clr_req_o      (clr_req[gi]),
                .tgt_o          (tgt[gi]),
                .stage_o        (stg[gi]),
                .done_o         (done[gi])
            );
        end
    endgenerate

    // Gather set requests onto the flag they target and clears onto own flags.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < P; i++) begin
            if (set_req[i]) begin
                set_vec[int'(tgt[i]) * S + int'(stg[i])] = 1'b1;
            end
            if (clr_req[i]) begin
                clr_vec[i * S + int'(stg[i])] = 1'b1;
            end
        end
    end

    // Present each agent with its partner's and its own flag for its round.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            pflag[i] = flags[int'(tgt[i]) * S + int'(stg[i])];
            oflag[i] = flags[i * S + int'(stg[i])];
        end
    end

    dsb_flag_array #(.NFLAG(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_q (flags)
    );

    AST_ONE_SETTER_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_vec) == $countones(set_req));  // R2
    AST_RESET_FLAGS_EMPTY: assert property (@(posedge clk)
        $past(!rst_n) |-> (flags == '0 && done == '0));  // R9

endmodule

// File: tb/tb_dsb_engine.sv
module tb_dsb_engine;

    localparam int P = 8;
    localparam int S = $clog2(P);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] start = '0;
    logic [P-1:0] done;
    logic [4:0]   start5 = '0;
    logic [4:0]   done5;
    logic [1:0]   start2 = '0;
    logic [1:0]   done2;

    dsb_engine #(.P(P)) dut    (.clk(clk), .rst_n(rst_n), .start(start),  .done(done));
    dsb_engine #(.P(5)) dut_p5 (.clk(clk), .rst_n(rst_n), .start(start5), .done(done5));
    dsb_engine #(.P(2)) dut_p2 (.clk(clk), .rst_n(rst_n), .start(start2), .done(done2));

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int last_start;
        int exact;
    } exp_t;

    exp_t         sb_q[$];
    logic [P-1:0] seen = '0;
    int           n_checks = 0;
    int           n_fail = 0;
    int           stray = 0;
    bit           finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: match done pulses of the eight-way group against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done != '0) begin
            if (sb_q.size() == 0) begin
                stray++;
                chk(1'b0, "R10", "done with no barrier pending", int'(done), 0);
            end else begin
                for (int i = 0; i < P; i++) begin
                    if (done[i]) begin
                        chk(!seen[i], "R10 R6", "second done in one barrier, participant", i, -1);
                        chk(cyc > sb_q[0].last_start, "R7", "done cycle vs last start", cyc, sb_q[0].last_start + 1);
                        if (sb_q[0].exact >= 0)
                            chk(cyc == sb_q[0].exact, "R1 R2 R4", "done cycle", cyc, sb_q[0].exact);
                        seen[i] = 1'b1;
                    end
                end
                if (&seen) begin
                    void'(sb_q.pop_front());
                    seen = '0;
                end
            end
        end
    end

    // Driver: participant i starts d[i] cycles after the call; optional restart.
    task automatic run_barrier(input int d[P], input bit restart);
        int   mx = 0;
        exp_t e;
        foreach (d[i]) if (d[i] > mx) mx = d[i];
        e.last_start = cyc + 1 + mx;
        e.exact      = (mx == 0) ? cyc + 1 + 4 * S : -1;
        sb_q.push_back(e);
        for (int t = 0; t <= mx; t++) begin
            for (int i = 0; i < P; i++) start[i] = (d[i] == t);
            @(negedge clk);
        end
        start = '0;
        if (restart) begin
            @(negedge clk);
            start = '1;   // R8: participants are busy here
            @(negedge clk);
            start = '0;
        end
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired, cycle", cyc, 20000);
        summary();
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        chk(done == '0 && done5 == '0 && done2 == '0, "R9", "done during reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == '0 && done5 == '0 && done2 == '0, "R9", "done after reset", int'(done), 0);

        // Simultaneous arrival, exact latency.
        run_barrier('{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
        // Back-to-back reuse of the flags (R3, R6).
        run_barrier('{0, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
        chk(sb_q.size() == 0, "R3 R6", "barrier reuse pending items", sb_q.size(), 0);
        // Scrambled staggered arrival.
        run_barrier('{0, 3, 1, 7, 2, 5, 4, 6}, 1'b0);
        // One participant very late (R7).
        run_barrier('{0, 0, 0, 0, 0, 40, 0, 0}, 1'b0);
        // Start strobed again while busy (R8): exact latency and single done.
        run_barrier('{0, 0, 0, 0, 0, 0, 0, 0}, 1'b1);
        repeat (4 * S + 4) @(negedge clk);
        chk(stray == 0, "R8", "extra dones from busy start", stray, 0);

        // Group of five: size not a power of two (R5), S = 3.
        start5 = '1;
        t0 = cyc + 1;
        @(negedge clk);
        start5 = '0;
        while (cyc < t0 + 4 * 3 - 1) @(negedge clk);
        chk(done5 == '0, "R5 R1", "P=5 done one cycle early", int'(done5), 0);
        @(negedge clk);
        chk(done5 == 5'h1f, "R5 R1", "P=5 done at 4S", int'(done5), 31);
        @(negedge clk);
        chk(done5 == '0, "R6", "P=5 done pulse width", int'(done5), 0);

        // Group of two: incoming equals outgoing partner (R5), S = 1.
        start2 = 2'b01;
        @(negedge clk);
        start2 = 2'b00;
        repeat (10) @(negedge clk);
        chk(done2 == '0, "R7", "P=2 done with one start", int'(done2), 0);
        start2 = 2'b10;
        t0 = cyc + 1;
        @(negedge clk);
        start2 = 2'b00;
        while (cyc < t0 + 4) begin
            if (done2 != '0) chk(1'b0, "R5", "P=2 early done", int'(done2), 0);
            @(negedge clk);
        end
        chk(done2 == 2'b11, "R5", "P=2 done after late start", int'(done2), 3);

        repeat (30) @(negedge clk);
        chk(stray == 0, "R10", "stray dones at end", stray, 0);
        chk(done == '0 && done5 == '0 && done2 == '0, "R6", "idle outputs at end", int'(done), 0);
        summary();
    end

endmodule